// File: doc/BRIEF.md
# Power-Domain Shutdown and Wake Sequencer

This always-on controller moves one switchable logic domain between a fully powered state and a fully unpowered state. Each move follows a fixed order. On the way down it raises the state-save control, clamps the domain's outputs, stops the domain clock and then opens every power switch together. On the way up it closes the switches in timed phases so that inrush current stays limited. It then waits for the virtual rail to report supply-good, restores the clock (with a slow-clock window first), removes the clamp and finally releases the save control.

Every spacing in both directions comes from a configuration input: the delay between steps, the time spent on each switch phase, the supply-settle limit and the length of the slow-clock window. If the rail does not report good in time, the block stops in a sticky fault state with the clamp held on and the clock off. Only reset clears it. A request of the opposite direction that arrives during a sequence is held and acted on once that sequence ends. A request that asks for the state the domain is already in is dropped.

Top module: `pgate_seq`

## Requirements
- R1: While reset is high and after it falls, with no request applied, the outputs show the powered state: save low, isolation low, clock enable high, every switch bit high, slow select low, dom_on high, dom_off low, busy low, timeout_err low.
- R2: A sleep request in the powered state raises save in the next cycle. Isolation rises D cycles later, the clock enable falls D cycles after that, and D cycles after that the switches open and dom_off rises. D is step_dly, and a value of zero counts as one.
- R3: A wake request in the off state turns on switch bit 0 in the next cycle. Each further bit, in ascending index order, turns on P cycles after the previous one. P is phase_dly, and zero counts as one.
- R4: Once all switch bits are on, the clock enable rises one cycle after the first cycle in which supply_good is sampled high. The clock enable stays low until that happens.
- R5: After the clock enable rises, isolation falls D cycles later and save falls D cycles after that. dom_on rises in the same cycle as save falls.
- R6: Isolation is high in every cycle in which any switch bit is low.
- R7: slow_clk_sel is high for exactly slow_cycles cycles, starting in the cycle the clock enable rises on wake. It is never high while the clock enable is low.
- R8: If supply_good is not seen within L cycles of all switch bits being on (L is settle_limit, zero counts as one), timeout_err rises. It then stays high, with isolation and save high, the clock enable low and the switches on, regardless of any request, until reset.
- R9: A wake request during power-down is held, and power-up starts in the cycle after dom_off rises. A sleep request during power-up is held, and power-down starts in the cycle after dom_on rises.
- R10: A wake request while powered, or a sleep request while off, changes no output and leaves no pending request behind.
- R11: Exactly one of dom_on, dom_off and busy is high in every cycle. busy covers every sequence step and the fault state.
- R12: On power-down all switch bits fall in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Request to power the domain down |
| wake_req | input | 1 | Request to power the domain up |
| supply_good | input | 1 | Virtual rail has settled |
| step_dly | input | CNT_W | Cycles between ordered steps (0 acts as 1) |
| phase_dly | input | CNT_W | Cycles per switch phase (0 acts as 1) |
| settle_limit | input | CNT_W | Cycles to wait for supply_good (0 acts as 1) |
| slow_cycles | input | CNT_W | Length of the slow-clock window after clock restore |
| save_ret | output | 1 | State-save control to retention storage |
| iso_en | output | 1 | Output clamp enable for the domain |
| clk_en | output | 1 | Domain clock enable |
| sw_en | output | N_PHASES | Power-switch enables, one per phase |
| slow_clk_sel | output | 1 | Selects the slow clock during restore |
| dom_on | output | 1 | Domain fully powered |
| dom_off | output | 1 | Domain fully unpowered |
| busy | output | 1 | Sequence or fault in progress |
| timeout_err | output | 1 | Sticky supply-settle timeout |

## Verification
The assertions assume that reset is high at time zero and that supply_good only matters while the sequencer waits for it. Because of that, no property ties the rail to the switch state. They also assume the configuration inputs stay fixed while a sequence runs. The stimulus changes the configuration only while the domain rests fully on or fully off. It raises supply_good only after all phases are on and lowers it once the domain is off. It chooses the supply arrival time either inside the settle window or never, so each run ends in a known state.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

    typedef enum logic [3:0] {
        ST_ON,
        ST_DN_SAVE,
        ST_DN_ISO,
        ST_DN_CLK,
        ST_OFF,
        ST_UP_SW,
        ST_UP_WAIT,
        ST_UP_CLK,
        ST_UP_ISO,
        ST_FAULT
    } pgs_state_e;

    typedef struct packed {
        logic save;
        logic iso;
        logic clk;
        logic sw_full;
        logic sw_ramp;
    } pgs_ctrl_t;

    function automatic pgs_ctrl_t ctrl_of(pgs_state_e s);
        pgs_ctrl_t c;
        case (s)
            ST_ON:      c = '{save: 1'b0, iso: 1'b0, clk: 1'b1, sw_full: 1'b1, sw_ramp: 1'b0};
            ST_DN_SAVE: c = '{save: 1'b1, iso: 1'b0, clk: 1'b1, sw_full: 1'b1, sw_ramp: 1'b0};
            ST_DN_ISO:  c = '{save: 1'b1, iso: 1'b1, clk: 1'b1, sw_full: 1'b1, sw_ramp: 1'b0};
            ST_DN_CLK:  c = '{save: 1'b1, iso: 1'b1, clk: 1'b0, sw_full: 1'b1, sw_ramp: 1'b0};
            ST_OFF:     c = '{save: 1'b1, iso: 1'b1, clk: 1'b0, sw_full: 1'b0, sw_ramp: 1'b0};
            ST_UP_SW:   c = '{save: 1'b1, iso: 1'b1, clk: 1'b0, sw_full: 1'b0, sw_ramp: 1'b1};
            ST_UP_CLK:  c = '{save: 1'b1, iso: 1'b1, clk: 1'b1, sw_full: 1'b1, sw_ramp: 1'b0};
            ST_UP_ISO:  c = '{save: 1'b1, iso: 1'b0, clk: 1'b1, sw_full: 1'b1, sw_ramp: 1'b0};
            default:    c = '{save: 1'b1, iso: 1'b1, clk: 1'b0, sw_full: 1'b1, sw_ramp: 1'b0};
        endcase
        return c;
    endfunction

    function automatic logic in_down(pgs_state_e s);
        return (s == ST_DN_SAVE) || (s == ST_DN_ISO) || (s == ST_DN_CLK);
    endfunction

    function automatic logic in_up(pgs_state_e s);
        return (s == ST_UP_SW) || (s == ST_UP_WAIT) || (s == ST_UP_CLK) || (s == ST_UP_ISO);
    endfunction

endpackage

// File: rtl/pgs_downcnt.sv
module pgs_downcnt #(
    parameter int W         = 8,
    parameter bit FLOOR_ONE = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt
);
    logic [W-1:0] start_val;

    generate
        if (FLOOR_ONE) begin : g_floor
            assign start_val = (load_val == '0) ? W'(1) : load_val;
        end else begin : g_raw
            assign start_val = load_val;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= start_val;
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end
endmodule

// File: rtl/pgs_req_latch.sv
module pgs_req_latch (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic arm,
    input  logic take,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (rst)
            pend <= 1'b0;
        else if (take)
            pend <= 1'b0;
        else if (req && arm)
            pend <= 1'b1;
    end
endmodule

// File: rtl/pgs_phase_dec.sv
module pgs_phase_dec #(
    parameter int N_PHASES = 4,
    parameter int PH_W     = 2
) (
    input  logic                full_on,
    input  logic                ramp_on,
    input  logic [PH_W-1:0]     idx,
    output logic [N_PHASES-1:0] sw
);
    generate
        for (genvar i = 0; i < N_PHASES; i++) begin : g_bit
            assign sw[i] = full_on | (ramp_on & (idx >= PH_W'(i)));
        end
    endgenerate
endmodule

// File: rtl/pgate_seq.sv
module pgate_seq
    import pgs_pkg::*;
#(
    parameter int N_PHASES = 4,
    parameter int CNT_W    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sleep_req,
    input  logic                wake_req,
    input  logic                supply_good,
    input  logic [CNT_W-1:0]    step_dly,
    input  logic [CNT_W-1:0]    phase_dly,
    input  logic [CNT_W-1:0]    settle_limit,
    input  logic [CNT_W-1:0]    slow_cycles,
    output logic                save_ret,
    output logic                iso_en,
    output logic                clk_en,
    output logic [N_PHASES-1:0] sw_en,
    output logic                slow_clk_sel,
    output logic                dom_on,
    output logic                dom_off,
    output logic                busy,
    output logic                timeout_err
);
    localparam int PH_W = (N_PHASES > 1) ? $clog2(N_PHASES) : 1;
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(N_PHASES - 1);

    pgs_state_e       state_q, state_d;
    logic [PH_W-1:0]  phase_q;
    logic             phase_adv;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic [CNT_W-1:0] tmr_cnt;
    logic             tmr_exp;
    logic             slow_load;
    logic [CNT_W-1:0] slow_cnt;
    logic             sleep_pend, wake_pend;
    logic             sleep_take, wake_take;
    pgs_ctrl_t        ctrl;

    assign tmr_exp = (tmr_cnt == CNT_W'(1));

    // next-state logic
    always_comb begin
        state_d   = state_q;
        phase_adv = 1'b0;
        case (state_q)
            ST_ON:      if (sleep_req || sleep_pend) state_d = ST_DN_SAVE;
            ST_DN_SAVE: if (tmr_exp) state_d = ST_DN_ISO;
            ST_DN_ISO:  if (tmr_exp) state_d = ST_DN_CLK;
            ST_DN_CLK:  if (tmr_exp) state_d = ST_OFF;
            ST_OFF:     if (wake_req || wake_pend) state_d = ST_UP_SW;
            ST_UP_SW: begin
                if (tmr_exp) begin
                    if (phase_q == LAST_PH) state_d = ST_UP_WAIT;
                    else                    phase_adv = 1'b1;
                end
            end
            ST_UP_WAIT: begin
                if (supply_good)  state_d = ST_UP_CLK;
                else if (tmr_exp) state_d = ST_FAULT;
            end
            ST_UP_CLK:  if (tmr_exp) state_d = ST_UP_ISO;
            ST_UP_ISO:  if (tmr_exp) state_d = ST_ON;
            default:    state_d = ST_FAULT;
        endcase
    end

    // step timer load selection
    always_comb begin
        tmr_load = (state_d != state_q) || phase_adv;
        case (state_d)
            ST_UP_SW:   tmr_val = phase_dly;
            ST_UP_WAIT: tmr_val = settle_limit;
            default:    tmr_val = step_dly;
        endcase
    end

    assign slow_load  = (state_d == ST_UP_CLK) && (state_q != ST_UP_CLK);
    assign sleep_take = (state_q == ST_ON)  && (state_d == ST_DN_SAVE);
    assign wake_take  = (state_q == ST_OFF) && (state_d == ST_UP_SW);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ON;
            phase_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_UP_SW)
                phase_q <= '0;
            else if (phase_adv)
                phase_q <= phase_q + PH_W'(1);
        end
    end

    pgs_downcnt #(.W(CNT_W), .FLOOR_ONE(1'b1)) u_step_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .cnt      (tmr_cnt)
    );

    pgs_downcnt #(.W(CNT_W), .FLOOR_ONE(1'b0)) u_slow_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (slow_load),
        .load_val (slow_cycles),
        .cnt      (slow_cnt)
    );

    pgs_req_latch u_sleep_hold (
        .clk  (clk),
        .rst  (rst),
        .req  (sleep_req),
        .arm  (in_up(state_q)),
        .take (sleep_take),
        .pend (sleep_pend)
    );

    pgs_req_latch u_wake_hold (
        .clk  (clk),
        .rst  (rst),
        .req  (wake_req),
        .arm  (in_down(state_q)),
        .take (wake_take),
        .pend (wake_pend)
    );

    assign ctrl = ctrl_of(state_q);

    pgs_phase_dec #(.N_PHASES(N_PHASES), .PH_W(PH_W)) u_phase_dec (
        .full_on (ctrl.sw_full),
        .ramp_on (ctrl.sw_ramp),
        .idx     (phase_q),
        .sw      (sw_en)
    );

    assign save_ret     = ctrl.save;
    assign iso_en       = ctrl.iso;
    assign clk_en       = ctrl.clk;
    assign slow_clk_sel = ctrl.clk && (slow_cnt != '0);
    assign dom_on       = (state_q == ST_ON);
    assign dom_off      = (state_q == ST_OFF);
    assign busy         = !dom_on && !dom_off;
    assign timeout_err  = (state_q == ST_FAULT);
endmodule

// File: rtl/pgs_seq_chk.sv
module pgs_seq_chk #(
    parameter int N_PHASES = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                supply_good,
    input logic                save_ret,
    input logic                iso_en,
    input logic                clk_en,
    input logic [N_PHASES-1:0] sw_en,
    input logic                slow_clk_sel,
    input logic                dom_on,
    input logic                dom_off,
    input logic                busy,
    input logic                timeout_err
);
    // R2
    clk_stop_order_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_en) |-> (save_ret && iso_en));

    // R3
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sw_en) && (sw_en != '0)) |-> ($countones(sw_en) == $countones($past(sw_en)) + 1));

    // R4
    clk_after_good_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_en) |-> $past(supply_good));

    // R4
    clk_needs_rail_chk: assert property (@(posedge clk) disable iff (rst)
        clk_en |-> (&sw_en));

    // R5
    iso_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(iso_en) |-> (clk_en && save_ret));

    // R5
    save_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(save_ret) |-> (!iso_en && clk_en));

    // R6
    clamp_while_unpowered_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_en != '1) |-> iso_en);

    // R7
    slow_only_clocked_chk: assert property (@(posedge clk) disable iff (rst)
        slow_clk_sel |-> clk_en);

    // R8
    fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        timeout_err |=> (timeout_err && iso_en && !clk_en));

    // R11
    status_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({dom_on, dom_off, busy}) == 1);

    // R12
    off_state_chk: assert property (@(posedge clk) disable iff (rst)
        dom_off |-> ((sw_en == '0) && iso_en && !clk_en));
endmodule

bind pgate_seq pgs_seq_chk #(.N_PHASES(N_PHASES)) u_seq_chk (
    .clk          (clk),
    .rst          (rst),
    .supply_good  (supply_good),
    .save_ret     (save_ret),
    .iso_en       (iso_en),
    .clk_en       (clk_en),
    .sw_en        (sw_en),
    .slow_clk_sel (slow_clk_sel),
    .dom_on       (dom_on),
    .dom_off      (dom_off),
    .busy         (busy),
    .timeout_err  (timeout_err)
);

// File: tb/tb_pgate_seq.sv
module tb_pgate_seq;
    localparam int N  = 4;
    localparam int CW = 8;
    localparam int OW = N + 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sleep_req = 1'b0, wake_req = 1'b0, supply_good = 1'b1;
    logic [CW-1:0] step_dly = 8'd1, phase_dly = 8'd1, settle_limit = 8'd4, slow_cycles = 8'd0;
    logic          save_ret, iso_en, clk_en, slow_clk_sel, dom_on, dom_off, busy, timeout_err;
    logic [N-1:0]  sw_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pgate_seq #(.N_PHASES(N), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .wake_req(wake_req),
        .supply_good(supply_good), .step_dly(step_dly), .phase_dly(phase_dly),
        .settle_limit(settle_limit), .slow_cycles(slow_cycles),
        .save_ret(save_ret), .iso_en(iso_en), .clk_en(clk_en), .sw_en(sw_en),
        .slow_clk_sel(slow_clk_sel), .dom_on(dom_on), .dom_off(dom_off),
        .busy(busy), .timeout_err(timeout_err)
    );

    function automatic logic [OW-1:0] pk(bit sv, bit is, bit ck, logic [N-1:0] sw,
                                         bit sl, bit on, bit off, bit bz, bit er);
        return {sv, is, ck, sw, sl, on, off, bz, er};
    endfunction

    function automatic logic [N-1:0] ramp_mask(int n);
        logic [N-1:0] m = '0;
        for (int j = 0; j < N; j++) m[j] = (j < n);
        return m;
    endfunction

    function automatic int eff(int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic logic [OW-1:0] obs();
        return {save_ret, iso_en, clk_en, sw_en, slow_clk_sel, dom_on, dom_off, busy, timeout_err};
    endfunction

    localparam logic [OW-1:0] PAT_ON  = {1'b0, 1'b0, 1'b1, {N{1'b1}}, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
    localparam logic [OW-1:0] PAT_OFF = {1'b1, 1'b1, 1'b0, {N{1'b0}}, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
    localparam logic [OW-1:0] PAT_ERR = {1'b1, 1'b1, 1'b0, {N{1'b1}}, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

    task automatic chk(string req, string what, logic [OW-1:0] got, logic [OW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got=%b exp=%b", req, what, got, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        sleep_req = 1'b0;
        wake_req = 1'b0;
        supply_good = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "during reset", obs(), PAT_ON);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "after reset", obs(), PAT_ON);
    endtask

    // power-down; optional wake pulse at cycle wake_at
    task automatic do_down(int d, int wake_at);
        int de   = eff(d);
        int koff = 1 + 3 * de;
        int kend = (wake_at >= 0) ? koff + 1 : koff;
        logic [OW-1:0] e;
        step_dly = CW'(d);
        @(negedge clk);
        sleep_req = 1'b1;
        for (int k = 1; k <= kend; k++) begin
            @(negedge clk);
            sleep_req = 1'b0;
            wake_req  = 1'b0;
            if (k <= koff) begin
                e = pk(1'b1, k >= 1 + de, k < 1 + 2 * de, (k >= koff) ? '0 : '1,
                       1'b0, 1'b0, k >= koff, k < koff, 1'b0);
                chk((k == koff) ? "R12" : "R2", $sformatf("down k=%0d", k), obs(), e);
            end else begin
                e = pk(1'b1, 1'b1, 1'b0, ramp_mask(1), 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
                chk("R9", "held wake starts power-up", obs(), e);
            end
            if (k == wake_at) wake_req = 1'b1;
        end
        if (wake_at < 0) supply_good = 1'b0;
    endtask

    // power-up; g<0 means the rail never reports good
    task automatic do_up(int p, int l, int s, int g, int d, int sleep_at);
        int pe = eff(p), le = eff(l), de = eff(d);
        int np = N * pe;
        int kg = (g >= 0) ? np + 1 + g : -1;
        int kc = kg + 1;
        int kon = kc + 2 * de;
        int kend = (g >= 0) ? kon + 1 : np + le + 3;
        logic [OW-1:0] e;
        string rq;
        phase_dly = CW'(p);
        settle_limit = CW'(l);
        slow_cycles = CW'(s);
        step_dly = CW'(d);
        supply_good = 1'b0;
        @(negedge clk);
        wake_req = 1'b1;
        for (int k = 1; k <= kend; k++) begin
            @(negedge clk);
            wake_req = 1'b0;
            sleep_req = 1'b0;
            if (k <= np) begin
                e = pk(1'b1, 1'b1, 1'b0, ramp_mask((k - 1) / pe + 1), 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
                rq = "R3";
            end else if (g < 0) begin
                e = (k < np + 1 + le) ? pk(1'b1, 1'b1, 1'b0, '1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0) : PAT_ERR;
                rq = "R8";
            end else if (k < kc) begin
                e = pk(1'b1, 1'b1, 1'b0, '1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
                rq = "R4";
            end else if (k < kon) begin
                e = pk(1'b1, k < kc + de, 1'b1, '1, (k - kc) < s, 1'b0, 1'b0, 1'b1, 1'b0);
                rq = ((k - kc) < s + 1) ? "R7" : "R5";
            end else if (k == kon || sleep_at < 0) begin
                e = pk(1'b0, 1'b0, 1'b1, '1, (k - kc) < s, 1'b1, 1'b0, 1'b0, 1'b0);
                rq = (k == kon) ? "R5" : "R10";
            end else begin
                e = pk(1'b1, 1'b0, 1'b1, '1, (k - kc) < s, 1'b0, 1'b0, 1'b1, 1'b0);
                rq = "R9";
            end
            chk(rq, $sformatf("up k=%0d", k), obs(), e);
            if (k == kg) supply_good = 1'b1;
            if (k == sleep_at) sleep_req = 1'b1;
        end
    endtask

    task automatic idle_check(int n, logic [OW-1:0] pat, string rq, string what);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sleep_req = 1'b0;
            wake_req = 1'b0;
            chk(rq, what, obs(), pat);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // wake while on is dropped
        @(negedge clk);
        wake_req = 1'b1;
        idle_check(4, PAT_ON, "R10", "wake while on");

        // zero step delay acts as one
        do_down(0, -1);

        // sleep while off is dropped
        @(negedge clk);
        sleep_req = 1'b1;
        idle_check(4, PAT_OFF, "R10", "sleep while off");

        // minimal up; kon+1 check shows no stale sleep
        do_up(0, 1, 0, 0, 0, -1);
        idle_check(2, PAT_ON, "R11", "settled on");

        // held sleep during power-up
        do_down(2, -1);
        do_up(2, 6, 3, 2, 2, 2);
        repeat (3 * 2 + 1) @(negedge clk);
        chk("R9", "held sleep reaches off", obs(), PAT_OFF);
        supply_good = 1'b0;

        // held wake during power-down
        do_up(1, 4, 2, 3, 1, -1);
        repeat (4) @(negedge clk);
        supply_good = 1'b1;
        do_down(3, 4);
        repeat (N * 1 + 2 * 3 + 6) @(negedge clk);
        chk("R9", "held wake reaches on", obs(), PAT_ON);

        // random sequences
        for (int it = 0; it < 30; it++) begin
            int d = $urandom_range(0, 5);
            int p = $urandom_range(0, 4);
            int l = $urandom_range(1, 9);
            int s = $urandom_range(0, 6);
            int g = $urandom_range(0, l - 1);
            supply_good = 1'b1;
            do_down(d, -1);
            repeat ($urandom_range(0, 3)) @(negedge clk);
            do_up(p, l, s, g, d, -1);
            repeat (s + 2) @(negedge clk);
        end

        // settle timeout, then ignored requests, then reset
        do_down(1, -1);
        do_up(2, 5, 1, -1, 1, -1);
        @(negedge clk);
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        sleep_req = 1'b1;
        idle_check(5, PAT_ERR, "R8", "fault holds");
        do_reset();

        // timeout edge: good arrives on the last allowed cycle
        do_down(1, -1);
        do_up(1, 3, 0, 2, 1, -1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired R1 got=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule